// File: doc/BRIEF.md
# NAND Sector Hamming Code Checker

This block sits beside the parity accumulator of a NAND flash controller that protects each 512-byte sector with a single-error-correcting Hamming code. On every transaction it takes the raw 32-bit parity word and turns it into the 24-bit code that is written to the spare area. The raw word carries two reserved nibbles, which the block drops. The block then inverts the packed value, so that a fully erased sector (all ones, data and spare alike) checks clean.

The same transaction also carries the 24-bit code read back from the spare area. The block XORs that stored code with the freshly packed code and puts the outcome into one of four classes: clean, a single flipped data bit that can be repaired, a flipped bit inside the stored code only, or damage beyond repair. For a repairable data error it reports the byte offset in the sector and an 8-bit mask that the data path XORs into that byte. Inputs are offered on a valid/ready handshake. Results are registered and stay on the outputs until the next accepted input.

Top module: `nand_ecc_check`

## Requirements
- R1: The calculated code is the bitwise inverse of {raw[27:16], raw[11:0]}; raw bits 31:28 and 15:12 have no effect. Both the calculated code and the stored code are carried with spare byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16.
- R2: A raw parity word of zero checked against a stored code of 24'hFFFFFF (erased sector) gives status 0.
- R3: When the calculated and stored codes are equal, status is 0 (clean). Whenever status is not 1, offset and mask are both zero.
- R4: Let d be calculated XOR stored. When d[23:12] is the bitwise complement of d[11:0], status is 1 (corrected), offset is d[23:15] and mask is 8'b1 shifted left by d[14:12].
- R5: A pattern that meets R4 but has an offset not below SECTOR_BYTES gives status 3 with zero offset and mask.
- R6: A d with exactly one bit set that does not meet R4 gives status 2 (code-only error) with zero mask.
- R7: Any other nonzero d gives status 3 (uncorrectable).
- R8: An input is accepted when in_valid and in_ready are both high. The results appear on the outputs after the clock edge that accepts the input, and out_valid is high for exactly that one cycle. Without an accepted input, every result output keeps its value.
- R9: While rst is high, in_ready, out_valid, out_code, out_status, out_offset and out_mask are all zero. in_ready is high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input transaction offered |
| in_ready | output | 1 | Block can accept a transaction |
| in_raw | input | 32 | Raw parity word from the accumulator |
| in_stored | input | 24 | Code read from the spare area, byte 0 in bits 7:0 |
| out_valid | output | 1 | One-cycle pulse when new results are presented |
| out_code | output | 24 | Packed, inverted code to store, byte 0 in bits 7:0 |
| out_status | output | 2 | 0 clean, 1 corrected, 2 code-only error, 3 uncorrectable |
| out_offset | output | 9 | Byte offset of the bad bit within the sector |
| out_mask | output | 8 | One-hot mask of the bit to flip in that byte |

## Verification
The bench first checks that reserved nibbles set in the raw word do not change the code. A design that failed to drop them would give erased or partly filled sectors a spurious mismatch. It probes the complement test at its extremes: offset 0 with bit 0, offset 511 with bit 7, and a difference whose halves are equal but not complementary, which a test on the XOR of the halves with the wrong polarity would wrongly accept. It separates single-bit differences at the top and bottom of the code from two-bit ones, so that a power-of-two test that is off by one is caught. A second instance with a 256-byte sector checks that an out-of-range offset is demoted to uncorrectable. It also checks that results hold while no input is accepted.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef enum logic [1:0] {
    ECC_CLEAN    = 2'd0,
    ECC_FIXED    = 2'd1,
    ECC_CODE_ERR = 2'd2,
    ECC_FATAL    = 2'd3
  } ecc_status_e;

endpackage

// File: rtl/ecc_code_pack.sv
module ecc_code_pack #(
  parameter int HALF_W = 12,
  parameter int RSV_W  = 4,
  localparam int SEG_W  = HALF_W + RSV_W,
  localparam int RAW_W  = 2 * SEG_W,
  localparam int CODE_W = 2 * HALF_W
) (
  input  logic [RAW_W-1:0]  raw,
  output logic [CODE_W-1:0] code
);

  logic [CODE_W-1:0] squeezed;

  // Each half keeps its low HALF_W bits; the reserved top nibble is dropped.
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign squeezed[h*HALF_W +: HALF_W] = raw[h*SEG_W +: HALF_W];
  end

  // Inverted so that an erased sector produces an all-ones code.
  assign code = ~squeezed;

endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import nand_ecc_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int IDX_W        = 3,
  parameter int SECTOR_BYTES = 512,
  localparam int CODE_W = 2 * HALF_W,
  localparam int OFF_W  = HALF_W - IDX_W,
  localparam int MASK_W = 1 << IDX_W
) (
  input  logic [CODE_W-1:0] calc,
  input  logic [CODE_W-1:0] stored,
  output ecc_status_e       status,
  output logic [OFF_W-1:0]  offset,
  output logic [MASK_W-1:0] mask
);

  logic [CODE_W-1:0] diff;
  logic [CODE_W-1:0] diff_m1;
  logic [HALF_W-1:0] hi_half;
  logic [HALF_W-1:0] lo_half;
  logic [OFF_W-1:0]  byte_pos;
  logic [IDX_W-1:0]  bit_pos;
  logic              is_zero;
  logic              is_compl;
  logic              is_single;
  logic              in_range;

  assign diff      = calc ^ stored;
  assign diff_m1   = diff - CODE_W'(1);
  assign hi_half   = diff[CODE_W-1:HALF_W];
  assign lo_half   = diff[HALF_W-1:0];
  assign byte_pos  = diff[CODE_W-1:HALF_W+IDX_W];
  assign bit_pos   = diff[HALF_W+IDX_W-1:HALF_W];
  assign is_zero   = (diff == '0);
  assign is_compl  = ((hi_half ^ lo_half) == '1);
  assign is_single = !is_zero && ((diff & diff_m1) == '0);
  assign in_range  = (32'(byte_pos) < 32'(SECTOR_BYTES));

  always_comb begin
    status = ECC_FATAL;
    offset = '0;
    mask   = '0;
    if (is_zero) begin
      status = ECC_CLEAN;
    end else if (is_compl) begin
      if (in_range) begin
        status = ECC_FIXED;
        offset = byte_pos;
        mask   = MASK_W'(1) << bit_pos;
      end
    end else if (is_single) begin
      status = ECC_CODE_ERR;
    end
  end

endmodule

// File: rtl/nand_ecc_check.sv
module nand_ecc_check
  import nand_ecc_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int RSV_W        = 4,
  parameter int IDX_W        = 3,
  parameter int SECTOR_BYTES = 512,
  localparam int RAW_W  = 2 * (HALF_W + RSV_W),
  localparam int CODE_W = 2 * HALF_W,
  localparam int OFF_W  = HALF_W - IDX_W,
  localparam int MASK_W = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RAW_W-1:0]  in_raw,
  input  logic [CODE_W-1:0] in_stored,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic [1:0]        out_status,
  output logic [OFF_W-1:0]  out_offset,
  output logic [MASK_W-1:0] out_mask
);

  logic              accept;
  logic [CODE_W-1:0] calc_code;
  ecc_status_e       cls_status;
  logic [OFF_W-1:0]  cls_offset;
  logic [MASK_W-1:0] cls_mask;

  logic              ready_q;
  logic              valid_q;
  logic [CODE_W-1:0] code_q;
  ecc_status_e       status_q;
  logic [OFF_W-1:0]  offset_q;
  logic [MASK_W-1:0] mask_q;

  assign accept = in_valid && ready_q;

  ecc_code_pack #(
    .HALF_W (HALF_W),
    .RSV_W  (RSV_W)
  ) pack_i (
    .raw  (in_raw),
    .code (calc_code)
  );

  ecc_classify #(
    .HALF_W       (HALF_W),
    .IDX_W        (IDX_W),
    .SECTOR_BYTES (SECTOR_BYTES)
  ) cls_i (
    .calc   (calc_code),
    .stored (in_stored),
    .status (cls_status),
    .offset (cls_offset),
    .mask   (cls_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q  <= 1'b0;
      valid_q  <= 1'b0;
      code_q   <= '0;
      status_q <= ECC_CLEAN;
      offset_q <= '0;
      mask_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      valid_q <= accept;
      if (accept) begin
        code_q   <= calc_code;
        status_q <= cls_status;
        offset_q <= cls_offset;
        mask_q   <= cls_mask;
      end
    end
  end

  assign in_ready   = ready_q;
  assign out_valid  = valid_q;
  assign out_code   = code_q;
  assign out_status = status_q;
  assign out_offset = offset_q;
  assign out_mask   = mask_q;

  AST_PULSE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid); // R8
  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !out_valid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(out_code) && $stable(out_status) &&
                 $stable(out_offset) && $stable(out_mask))); // R8
  AST_FIXED_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    (out_status == 2'd1) |-> ($countones(out_mask) == 1)); // R4
  AST_QUIET_WHEN_UNFIXED: assert property (@(posedge clk) disable iff (rst)
    (out_status != 2'd1) |-> (out_mask == '0 && out_offset == '0)); // R3
  AST_OFFSET_IN_SECTOR: assert property (@(posedge clk) disable iff (rst)
    (out_status == 2'd1) |-> (32'(out_offset) < 32'(SECTOR_BYTES))); // R5
  AST_CODE_ERR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (accept && cls_status == ECC_CODE_ERR) |=>
      ($countones(out_code ^ $past(in_stored)) == 1)); // R6

endmodule

// File: tb/nand_ecc_check_tb_top.sv
`timescale 1ns/1ps
module nand_ecc_check_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_raw = '0;
  logic [23:0] in_stored = '0;
  logic        in_ready, out_valid;
  logic [23:0] out_code;
  logic [1:0]  out_status;
  logic [8:0]  out_offset;
  logic [7:0]  out_mask;
  logic        s_ready, s_valid;
  logic [23:0] s_code;
  logic [1:0]  s_status;
  logic [8:0]  s_offset;
  logic [7:0]  s_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nand_ecc_check dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_raw(in_raw), .in_stored(in_stored), .out_valid(out_valid),
    .out_code(out_code), .out_status(out_status), .out_offset(out_offset),
    .out_mask(out_mask)
  );

  nand_ecc_check #(.SECTOR_BYTES(256)) dut_small_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(s_ready),
    .in_raw(in_raw), .in_stored(in_stored), .out_valid(s_valid),
    .out_code(s_code), .out_status(s_status), .out_offset(s_offset),
    .out_mask(s_mask)
  );

  // {raw, stored, code, status, offset, mask, status with 256-byte sector}
  localparam int NV = 12;
  localparam logic [100:0] VEC [NV] = '{
    {32'h0000_0000, 24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'd0,   8'h00, 2'd0}, // R2 erased
    {32'hF000_F000, 24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'd0,   8'h00, 2'd0}, // R1 reserved only
    {32'h0ABC_0123, 24'h543EDC, 24'h543EDC, 2'd0, 9'd0,   8'h00, 2'd0}, // R1 R3
    {32'hFABC_F123, 24'h543EDC, 24'h543EDC, 2'd0, 9'd0,   8'h00, 2'd0}, // R1 reserved set
    {32'h0000_0000, 24'hA5C5A3, 24'hFFFFFF, 2'd1, 9'd180, 8'h08, 2'd1}, // R4
    {32'h0000_0000, 24'h000FFF, 24'hFFFFFF, 2'd1, 9'd511, 8'h80, 2'd3}, // R4 R5
    {32'h0000_0000, 24'hFFF000, 24'hFFFFFF, 2'd1, 9'd0,   8'h01, 2'd1}, // R4 low corner
    {32'h0ABC_0123, 24'h0E0480, 24'h543EDC, 2'd1, 9'd180, 8'h08, 2'd1}, // R4
    {32'h0000_0000, 24'hFFFFFE, 24'hFFFFFF, 2'd2, 9'd0,   8'h00, 2'd2}, // R6
    {32'h0000_0000, 24'h7FFFFF, 24'hFFFFFF, 2'd2, 9'd0,   8'h00, 2'd2}, // R6
    {32'h0000_0000, 24'hFFFFFC, 24'hFFFFFF, 2'd3, 9'd0,   8'h00, 2'd3}, // R7
    {32'h0000_0000, 24'h000000, 24'hFFFFFF, 2'd3, 9'd0,   8'h00, 2'd3}  // R7 equal halves
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string status_req(logic [1:0] st);
    case (st)
      2'd0:    return "R3";
      2'd1:    return "R4";
      2'd2:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic send(logic [31:0] raw, logic [23:0] stored);
    @(negedge clk);
    in_raw = raw; in_stored = stored; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100us;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [23:0] held_code;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9", "in_ready in reset", 32'(in_ready), 0);
    chk("R9", "out_valid in reset", 32'(out_valid), 0);
    chk("R9", "outputs in reset",
        {out_code, out_status, out_offset[5:0]}, 0);
    chk("R9", "mask/offset in reset", {out_offset, out_mask}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "in_ready after reset", 32'(in_ready), 1);

    for (int i = 0; i < NV; i++) begin
      logic [100:0] v;
      v = VEC[i];
      send(v[100:69], v[68:45]);
      chk("R8", "out_valid pulse", 32'(out_valid), 1);
      chk("R1", "code", 32'(out_code), 32'(v[44:21]));
      chk("R1", "code byte0 position", 32'(out_code[7:0]), 32'(v[28:21]));
      chk(status_req(v[20:19]), "status", 32'(out_status), 32'(v[20:19]));
      chk(status_req(v[20:19]), "offset", 32'(out_offset), 32'(v[18:10]));
      chk(status_req(v[20:19]), "mask", 32'(out_mask), 32'(v[9:2]));
      chk("R5", "small sector status", 32'(s_status), 32'(v[1:0]));
      if (v[1:0] == 2'd3 && v[20:19] == 2'd1)
        chk("R5", "small sector mask/offset", {s_offset, s_mask}, 0);
    end

    // R2 directed erased sector
    send(32'h0, 24'hFFFFFF);
    chk("R2", "erased status", 32'(out_status), 0);

    // R8 hold: a mismatching input without in_valid changes nothing
    send(32'h0, 24'hA5C5A3);
    held_code = out_code;
    @(negedge clk);
    chk("R8", "out_valid drops", 32'(out_valid), 0);
    in_raw = 32'h0ABC_0123; in_stored = 24'h000000;
    repeat (2) @(negedge clk);
    chk("R8", "status held", 32'(out_status), 1);
    chk("R8", "offset/mask held", {out_offset, out_mask}, {9'd180, 8'h08});
    chk("R8", "code held", 32'(out_code), 32'(held_code));
    chk("R8", "no pulse idle", 32'(out_valid), 0);

    // R9 reset mid-run clears results
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R9", "status after reset", 32'(out_status), 0);
    chk("R9", "code after reset", 32'(out_code), 0);
    chk("R9", "ready in reset", 32'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule